// File: doc/BRIEF.md
# Bit-error-rate loss-of-signal detector

This block estimates the bit error rate of a recovered serial stream and raises a loss-of-signal alarm when that rate is too high. It needs no known test pattern. Each recovered bit arrives as a pair of samples from a bang-bang phase detector: a mid-eye sample of the bit, and a crossing sample taken between the previous bit and this one. If two consecutive mid-eye samples are equal, no transition happened between those bits. A crossing sample that differs from them then marks a false transition. These events are counted over a fixed window of bits. The count is compared with one of four limits, chosen by a 2-bit rate select.

The samples arrive on a valid/ready stream. The block never applies back-pressure: `smp_ready` is held high, so every cycle with `smp_valid` high transfers one bit. Cycles with `smp_valid` low carry no bit and change no state.

The alarm is a registered level output. It rises in the clock edge that accepts the error that brings the window's count up to the selected limit. It falls only at a window boundary, and only after a run of consecutive windows whose error count stayed below half the limit. By default the window is 65,536 bits, the run is 5 windows, and the limits are 33, 66, 131 and 262 errors. All of these are parameters. Reset is synchronous and active high.

Top module: `ber_los_monitor`

## Requirements
- R1: An accepted bit is a false transition when its mid-eye sample equals the previous accepted bit's mid-eye sample and its crossing sample has the opposite value. Bits whose mid-eye samples differ, or whose crossing sample matches, are not errors.
- R2: The first accepted bit after reset is never counted as an error, because it has no previous mid-eye sample.
- R3: `smp_ready` is always 1. A cycle with `smp_valid` = 0 is ignored entirely: it neither counts an error nor advances the window, whatever the sample inputs carry.
- R4: Errors are counted per window of 2^WIN_LOG2 accepted bits (65,536 by default). The count restarts at zero for each new window, so errors split across two windows do not add up.
- R5: `rate_sel` picks the limit. 2'b00 selects LIM_S0 (default 33), 2'b01 selects LIM_S1 (66), 2'b10 selects LIM_S2 (131) and 2'b11 selects LIM_S3 (262). `los_alarm` goes to 1 after the clock edge that accepts the error bringing the window's count to the limit, and no earlier.
- R6: After reset `los_alarm` is 0, and it stays 0 while no window reaches the limit.
- R7: While the alarm is high, a window that ends with an error count below half the limit (rounded down) is a clean window. The alarm goes to 0 at the end of the CLEAN_WINS-th consecutive clean window (default 5).
- R8: While the alarm is high, a window whose error count is at or above half the limit ends the run of clean windows. After it, a full new run of CLEAN_WINS clean windows is needed before release.
- R9: Once set, `los_alarm` stays 1 on every cycle that is not the final cycle of a release run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample pair valid for this cycle |
| smp_ready | output | 1 | Always 1; the block never stalls |
| smp_eye | input | 1 | Mid-eye data sample of the current bit |
| smp_xing | input | 1 | Crossing sample between previous and current bit |
| rate_sel | input | 2 | Error-limit select |
| los_alarm | output | 1 | Loss-of-signal alarm, high when active |

## Verification
The embedded assertions check properties that must hold on every cycle. Idle cycles freeze the window and error counters. A window end returns both counters to zero. A saturated error count holds its value. The first bit after reset never registers a hit. The alarm rises only when the limit is reached, and it falls only at a window boundary that ends the required run of clean windows. Other properties need scenarios and a reference model. These include the exact bit on which each select's limit trips, the non-accumulation of errors split across a window boundary, the reset of the clean run by a window at exactly half the limit, and the exact cycle of release. The bench drives these scenarios with a smaller window so that release fits in a short run.

// File: rtl/ber_los_pkg.sv
package ber_los_pkg;

  typedef enum logic [1:0] {
    SEL_HALF = 2'b00,
    SEL_ONE  = 2'b01,
    SEL_TWO  = 2'b10,
    SEL_FOUR = 2'b11
  } ber_sel_e;

  typedef struct packed {
    logic eye;
    logic xing;
  } bb_pair_t;

  function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                          input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/ber_false_trans.sv
module ber_false_trans
  import ber_los_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     take,
  input  bb_pair_t smp,
  output logic     hit
);

  logic have_prev;
  logic prev_eye;

  always_ff @(posedge clk) begin
    if (rst) begin
      have_prev <= 1'b0;
      prev_eye  <= 1'b0;
    end else if (take) begin
      have_prev <= 1'b1;
      prev_eye  <= smp.eye;
    end
  end

  assign hit = take && have_prev && (smp.eye == prev_eye) && (smp.xing != smp.eye);

  // first accepted bit after reset is never an error (R2)
  p_first_unchecked_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && take) |-> !hit);

endmodule

// File: rtl/ber_err_window.sv
module ber_err_window
  import ber_los_pkg::*;
#(
  parameter int unsigned WIN_LOG2 = 16,
  parameter int unsigned LIM_S0   = 33,
  parameter int unsigned LIM_S1   = 66,
  parameter int unsigned LIM_S2   = 131,
  parameter int unsigned LIM_S3   = 262,
  parameter int unsigned CNT_W    = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             hit,
  input  logic [1:0]       sel,
  output logic             win_end,
  output logic             reach,
  output logic [CNT_W-1:0] final_cnt,
  output logic [CNT_W-1:0] lim
);

  logic [WIN_LOG2-1:0] bit_cnt;
  logic [CNT_W-1:0]    err_cnt;
  logic [CNT_W-1:0]    cnt_inc;
  logic                last;

  always_comb begin
    unique case (ber_sel_e'(sel))
      SEL_HALF: lim = CNT_W'(LIM_S0);
      SEL_ONE:  lim = CNT_W'(LIM_S1);
      SEL_TWO:  lim = CNT_W'(LIM_S2);
      default:  lim = CNT_W'(LIM_S3);
    endcase
  end

  assign last    = &bit_cnt;
  assign cnt_inc = (hit && (err_cnt < lim)) ? err_cnt + CNT_W'(1) : err_cnt;
  assign win_end = take && last;
  assign reach   = take && (cnt_inc >= lim);
  assign final_cnt = cnt_inc;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt <= '0;
      err_cnt <= '0;
    end else if (take) begin
      bit_cnt <= bit_cnt + WIN_LOG2'(1);
      err_cnt <= last ? '0 : cnt_inc;
    end
  end

  // idle cycles change nothing (R3)
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !take |=> ($stable(bit_cnt) && $stable(err_cnt)));

  // every window starts from an empty count (R4)
  p_win_restart_r4: assert property (@(posedge clk) disable iff (rst)
    win_end |=> (bit_cnt == '0 && err_cnt == '0));

  // saturated count never wraps (R4)
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    (take && !last && err_cnt >= lim) |=> (err_cnt == $past(err_cnt)));

endmodule

// File: rtl/ber_los_hyst.sv
module ber_los_hyst #(
  parameter int unsigned CNT_W      = 9,
  parameter int unsigned CLEAN_WINS = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             win_end,
  input  logic             reach,
  input  logic [CNT_W-1:0] final_cnt,
  input  logic [CNT_W-1:0] lim,
  output logic             alarm
);

  localparam int unsigned CLN_W = $clog2(CLEAN_WINS + 1);

  logic [CLN_W-1:0] clean_cnt;
  logic [CNT_W-1:0] half;
  logic             quiet;

  assign half  = lim >> 1;
  assign quiet = (final_cnt < half) && !reach;

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm     <= 1'b0;
      clean_cnt <= '0;
    end else begin
      if (reach) alarm <= 1'b1;
      if (!alarm) begin
        clean_cnt <= '0;
      end else if (win_end) begin
        if (!quiet) begin
          clean_cnt <= '0;
        end else if (clean_cnt == CLN_W'(CLEAN_WINS - 1)) begin
          alarm     <= 1'b0;
          clean_cnt <= '0;
        end else begin
          clean_cnt <= clean_cnt + CLN_W'(1);
        end
      end
    end
  end

  // alarm rises only when the window count reaches the limit (R5)
  p_rise_on_limit_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm) |-> $past(reach));

  // alarm falls only at a window end closing a full clean run (R7, R9)
  p_fall_at_boundary_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(alarm) |-> ($past(win_end) && $past(clean_cnt) == CLN_W'(CLEAN_WINS - 1)));

endmodule

// File: rtl/ber_los_monitor.sv
module ber_los_monitor
  import ber_los_pkg::*;
#(
  parameter int unsigned WIN_LOG2   = 16,
  parameter int unsigned LIM_S0     = 33,
  parameter int unsigned LIM_S1     = 66,
  parameter int unsigned LIM_S2     = 131,
  parameter int unsigned LIM_S3     = 262,
  parameter int unsigned CLEAN_WINS = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       smp_valid,
  output logic       smp_ready,
  input  logic       smp_eye,
  input  logic       smp_xing,
  input  logic [1:0] rate_sel,
  output logic       los_alarm
);

  localparam int unsigned LIM_MAX = max_of4(LIM_S0, LIM_S1, LIM_S2, LIM_S3);
  localparam int unsigned CNT_W   = $clog2(LIM_MAX + 1);

  bb_pair_t         pair;
  logic             take;
  logic             hit;
  logic             win_end;
  logic             reach;
  logic [CNT_W-1:0] final_cnt;
  logic [CNT_W-1:0] lim;

  assign smp_ready = 1'b1;
  assign take      = smp_valid && smp_ready;
  assign pair      = '{eye: smp_eye, xing: smp_xing};

  ber_false_trans u_det (
    .clk (clk),
    .rst (rst),
    .take(take),
    .smp (pair),
    .hit (hit)
  );

  ber_err_window #(
    .WIN_LOG2(WIN_LOG2),
    .LIM_S0  (LIM_S0),
    .LIM_S1  (LIM_S1),
    .LIM_S2  (LIM_S2),
    .LIM_S3  (LIM_S3),
    .CNT_W   (CNT_W)
  ) u_win (
    .clk      (clk),
    .rst      (rst),
    .take     (take),
    .hit      (hit),
    .sel      (rate_sel),
    .win_end  (win_end),
    .reach    (reach),
    .final_cnt(final_cnt),
    .lim      (lim)
  );

  ber_los_hyst #(
    .CNT_W     (CNT_W),
    .CLEAN_WINS(CLEAN_WINS)
  ) u_hyst (
    .clk      (clk),
    .rst      (rst),
    .win_end  (win_end),
    .reach    (reach),
    .final_cnt(final_cnt),
    .lim      (lim),
    .alarm    (los_alarm)
  );

  // alarm is low coming out of reset (R6)
  p_reset_low_r6: assert property (@(posedge clk)
    rst |=> !los_alarm);

endmodule

// File: tb/ber_los_monitor_tb_top.sv
module ber_los_monitor_tb_top;

  localparam int WLOG  = 6;
  localparam int WIN   = 1 << WLOG;
  localparam int CLEAN = 5;
  localparam int L0 = 3, L1 = 5, L2 = 8, L3 = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       smp_valid = 1'b0;
  logic       smp_eye = 1'b0;
  logic       smp_xing = 1'b0;
  logic [1:0] rate_sel = 2'b00;
  logic       smp_ready;
  logic       los_alarm;

  int    vecs = 0;
  int    bad = 0;
  string cur_tag = "R6";
  bit    done = 0;

  int    bits = 0;
  logic  lm = 1'b0;

  // reference model state
  int    m_pos = 0, m_errs = 0, m_clean = 0;
  bit    m_alarm = 0, m_have = 0;
  logic  m_prev = 1'b0;

  always #10 clk = ~clk;

  ber_los_monitor #(
    .WIN_LOG2(WLOG), .LIM_S0(L0), .LIM_S1(L1), .LIM_S2(L2), .LIM_S3(L3),
    .CLEAN_WINS(CLEAN)
  ) dut_i (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_eye(smp_eye), .smp_xing(smp_xing), .rate_sel(rate_sel),
    .los_alarm(los_alarm)
  );

  function automatic int lim_of(input logic [1:0] s);
    case (s)
      2'b00: return L0;
      2'b01: return L1;
      2'b10: return L2;
      default: return L3;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_pos = 0; m_errs = 0; m_clean = 0; m_alarm = 0; m_have = 0; m_prev = 1'b0;
    end else if (smp_valid) begin
      bit was_high;
      int lim;
      was_high = m_alarm;
      lim = lim_of(rate_sel);
      if (m_have && smp_eye == m_prev && smp_xing != smp_eye) m_errs++;
      m_have = 1;
      m_prev = smp_eye;
      if (m_errs >= lim) m_alarm = 1;
      if (!was_high) m_clean = 0;
      else if (m_pos == WIN - 1) begin
        if (m_errs >= lim / 2) m_clean = 0;
        else begin
          m_clean++;
          if (m_clean == CLEAN) begin m_alarm = 0; m_clean = 0; end
        end
      end
      if (m_pos == WIN - 1) begin m_pos = 0; m_errs = 0; end
      else m_pos++;
    end
  end

  always @(posedge clk) begin
    #5;
    if (!done) begin
      vecs++;
      if (los_alarm !== m_alarm) begin
        bad++;
        $display("FAIL %s: los_alarm=%b expected %b at bit %0d", cur_tag, los_alarm, m_alarm, bits);
      end
      vecs++;
      if (smp_ready !== 1'b1) begin
        bad++;
        $display("FAIL R3: smp_ready=%b expected 1", smp_ready);
      end
    end
  end

  task automatic send(input logic v, input logic m, input logic x);
    @(negedge clk);
    smp_valid = v; smp_eye = m; smp_xing = x;
    if (v) begin bits++; lm = m; end
  endtask

  task automatic clean_bit();  send(1'b1, ~lm, ~lm); endtask
  task automatic flat_bit();   send(1'b1, lm, lm);   endtask
  task automatic err_bit();    send(1'b1, lm, ~lm);  endtask
  task automatic idle_cyc();   send(1'b0, ~lm, lm);  endtask

  task automatic errs(input int n);
    for (int i = 0; i < n; i++) err_bit();
  endtask

  task automatic cleans(input int n);
    for (int i = 0; i < n; i++) clean_bit();
  endtask

  task automatic pad_to(input int k);
    while ((bits % WIN) != ((WIN - k) % WIN)) clean_bit();
  endtask

  task automatic do_reset(input logic [1:0] s);
    @(negedge clk);
    rst = 1'b1; smp_valid = 1'b0; rate_sel = s;
    repeat (2) @(negedge clk);
    rst = 1'b0; bits = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    // R6: reset state and quiet operation
    cur_tag = "R6";
    do_reset(2'b00);
    repeat (4) idle_cyc();

    // R1: only equal-eye, opposite-crossing bits count
    cur_tag = "R1";
    cleans(40);
    for (int i = 0; i < 10; i++) flat_bit();
    cleans(5);
    errs(2);
    cleans(1);
    errs(1);

    // R2: first bit after reset is not checked
    cur_tag = "R2";
    do_reset(2'b00);
    errs(3);
    idle_cyc();
    errs(1);

    // R3: invalid cycles are ignored
    cur_tag = "R3";
    do_reset(2'b00);
    errs(1);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      smp_valid = 1'b0; smp_eye = i[0]; smp_xing = ~i[0];
    end
    errs(1);
    for (int i = 0; i < 5; i++) idle_cyc();
    errs(1);

    // R5: each select trips exactly on its limit
    cur_tag = "R5";
    for (int s = 0; s < 4; s++) begin
      do_reset(2'(s));
      clean_bit();
      errs(lim_of(2'(s)) - 1);
      cleans(3);
      err_bit();
      cleans(2);
    end

    // R4: errors split across a window boundary do not add
    cur_tag = "R4";
    do_reset(2'b01);
    pad_to(4);
    errs(4);
    errs(4);
    cleans(3);
    err_bit();

    // R7 and R9: hold through clean windows, release at the end of the fifth
    cur_tag = "R9";
    pad_to(0);
    cleans(WIN * (CLEAN - 1) + WIN - 1);
    cur_tag = "R7";
    cleans(10);

    // R8: a window at exactly half the limit restarts the clean run
    cur_tag = "R8";
    do_reset(2'b01);
    clean_bit();
    errs(5);
    pad_to(0);
    cleans(WIN * 3);
    errs(2);
    cleans(WIN - 2);
    err_bit();
    cleans(WIN - 1);
    cleans(WIN * 3 - 1);
    cur_tag = "R7";
    cleans(WIN + 10);

    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

endmodule